// File: doc/BRIEF.md
# Receive Character Queue with Error Reporting and Flow Control

This block sits between a serial receiver and the CPU of one communication channel. The receiver hands it each assembled character together with three status flags (framing error, parity error, received break), and the CPU drains it one character at a time. The queue is shallow, three characters by default. A push that arrives while every slot is taken is thrown away and raises an overrun flag.

The CPU sees status in one of two modes. In character mode the flags belong only to the character now at the head of the queue. In block mode the flags are sticky: they collect every error that has shown up at the head since the CPU last issued an error-clear command. The block also chooses the source of the receiver interrupt (queue not empty, or queue full). It drives an active-low request-to-send line that follows a software request, but that line is pulled inactive when a new start bit is seen while the queue is full, and it comes back on its own once a slot frees up.

Two state machines carry the behaviour. The occupancy machine has the states LVL_EMPTY, LVL_PART and LVL_FULL. It takes the transitions empty-to-part on an accepted push, part-to-full when the count reaches the depth, part-to-empty when the last character is popped, full-to-part on a pop, and part-to-part on balanced traffic. The flow machine has the states FLOW_OPEN and FLOW_HELD. It moves from open to held on a start bit while full with the automatic mode enabled, and from held to open once the queue is no longer full.

Top module: `rxq_top`

## Requirements
- R1: Characters leave in arrival order. `rd_data_o` shows the head character, and `rx_ready_o` is 1 exactly when at least one character is held.
- R2: A pop while the queue is empty has no effect: the next pushed character becomes the head.
- R3: The queue holds DEPTH characters, and `fifo_full_o` is 1 when all are taken. A push in a cycle that starts with the queue full is dropped, even when a pop happens in the same cycle, and it sets `overrun_o` from the next cycle on.
- R4: A push and a pop in the same cycle on a partly filled queue are both performed, and the occupancy does not change.
- R5: With `blk_mode_i`=0, `fe_o`/`pe_o`/`brk_o` equal the flags stored with the head character, and they are all 0 when the queue is empty.
- R6: With `blk_mode_i`=1, each reported flag is the OR of that flag over every character that has been at the head since the last error-clear, including the current head.
- R7: A pulse on `rst_err_i` clears the collected block-mode flags and `overrun_o` from the next cycle on. The clear wins over an overrun in the same cycle.
- R8: `irq_o` follows `rx_ready_o` when `irq_full_sel_i`=0 and `fifo_full_o` when it is 1.
- R9: With `rts_auto_en_i`=1, a `start_bit_i` pulse while full makes `rts_n_o` 1 from the next cycle. With `rts_auto_en_i`=0, or when the queue is not full, the pulse has no effect on `rts_n_o`.
- R10: `rts_n_o` is 0 only when `rts_sw_i`=1 and no automatic hold is active. A hold ends by itself two cycles after the pop that frees a slot, without any change to `rts_sw_i`.
- R11: After reset the queue is empty, `overrun_o` and all status flags are 0, and no hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Receiver delivers a character |
| push_data_i | input | DATA_W | Character to store |
| push_fe_i | input | 1 | Framing error of the pushed character |
| push_pe_i | input | 1 | Parity error of the pushed character |
| push_brk_i | input | 1 | Pushed character is a break |
| start_bit_i | input | 1 | Receiver detected a valid start bit |
| pop_i | input | 1 | CPU takes the head character |
| rst_err_i | input | 1 | Error-clear command |
| blk_mode_i | input | 1 | 1 selects block (sticky) status |
| irq_full_sel_i | input | 1 | 1 selects full as interrupt source |
| rts_auto_en_i | input | 1 | Enables automatic RTS hold |
| rts_sw_i | input | 1 | Software RTS request, 1 = assert |
| rd_data_o | output | DATA_W | Head character |
| rx_ready_o | output | 1 | Queue not empty |
| fifo_full_o | output | 1 | Queue full |
| fe_o | output | 1 | Reported framing error |
| pe_o | output | 1 | Reported parity error |
| brk_o | output | 1 | Reported break |
| overrun_o | output | 1 | A character was dropped |
| irq_o | output | 1 | Receiver interrupt request |
| rts_n_o | output | 1 | Request-to-send, active low |

## Verification
The bench builds the block with its default values: DEPTH of 3 and DATA_W of 8. The shallow depth means three pushes fill the queue, so the full flag, dropped pushes, a push meeting a pop on a full queue, and the full-queue start-bit hold all come up after a few cycles each. The 8-bit width lets every character in a scenario carry a distinct value, so the order of arrival and the absence of dropped characters can be read straight off the data output.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic brk;
        logic pe;
        logic fe;
    } rxq_err_t;

    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_PART  = 2'd1,
        LVL_FULL  = 2'd2
    } rxq_lvl_e;

    typedef enum logic {
        FLOW_OPEN = 1'b0,
        FLOW_HELD = 1'b1
    } rxq_flow_e;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  rxq_err_t          push_err_i,
    input  logic              pop_i,
    input  logic              rst_err_i,
    output logic [DATA_W-1:0] head_data_o,
    output rxq_err_t          head_err_o,
    output logic              not_empty_o,
    output logic              full_o,
    output logic              overrun_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] data_mem [DEPTH];
    rxq_err_t          err_mem  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count_q, count_d;
    rxq_lvl_e          lvl_q, lvl_d;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push_i && (lvl_q != LVL_FULL);
    assign do_pop  = pop_i  && (lvl_q != LVL_EMPTY);
    assign count_d = count_q + CNT_W'(do_push) - CNT_W'(do_pop);

    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_EMPTY: lvl_d = do_push ? LVL_PART : LVL_EMPTY;
            LVL_PART: begin
                if (count_d == '0)
                    lvl_d = LVL_EMPTY;
                else if (count_d == FULL_CNT)
                    lvl_d = LVL_FULL;
                else
                    lvl_d = LVL_PART;
            end
            LVL_FULL:  lvl_d = do_pop ? LVL_PART : LVL_FULL;
            default:   lvl_d = LVL_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q     <= LVL_EMPTY;
            count_q   <= '0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            overrun_o <= 1'b0;
        end else begin
            lvl_q   <= lvl_d;
            count_q <= count_d;
            if (do_push) wr_ptr <= ptr_step(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_step(rd_ptr);
            if (rst_err_i)
                overrun_o <= 1'b0;
            else if (push_i && lvl_q == LVL_FULL)
                overrun_o <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            data_mem[wr_ptr] <= push_data_i;
            err_mem[wr_ptr]  <= push_err_i;
        end
    end

    assign head_data_o = data_mem[rd_ptr];
    assign head_err_o  = err_mem[rd_ptr];
    assign not_empty_o = (lvl_q != LVL_EMPTY);
    assign full_o      = (lvl_q == LVL_FULL);

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rxq_err_t head_err_i,
    input  logic     head_valid_i,
    input  logic     blk_mode_i,
    input  logic     rst_err_i,
    output rxq_err_t report_o
);

    rxq_err_t acc_q;
    rxq_err_t head_seen;

    assign head_seen = head_valid_i ? head_err_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (rst_err_i)
            acc_q <= '0;
        else
            acc_q <= acc_q | head_seen;
    end

    assign report_o = blk_mode_i ? (acc_q | head_seen) : head_seen;

endmodule

// File: rtl/rxq_flow.sv
module rxq_flow
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en_i,
    input  logic start_bit_i,
    input  logic full_i,
    input  logic sw_req_i,
    output logic rts_n_o
);

    rxq_flow_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLOW_OPEN: if (auto_en_i && start_bit_i && full_i) st_d = FLOW_HELD;
            FLOW_HELD: if (!full_i) st_d = FLOW_OPEN;
            default:   st_d = FLOW_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLOW_OPEN;
        else        st_q <= st_d;
    end

    always_comb begin
        rts_n_o = 1'b1;
        unique case (st_q)
            FLOW_OPEN: rts_n_o = !sw_req_i;
            FLOW_HELD: rts_n_o = 1'b1;
            default:   rts_n_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              push_fe_i,
    input  logic              push_pe_i,
    input  logic              push_brk_i,
    input  logic              start_bit_i,
    input  logic              pop_i,
    input  logic              rst_err_i,
    input  logic              blk_mode_i,
    input  logic              irq_full_sel_i,
    input  logic              rts_auto_en_i,
    input  logic              rts_sw_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rx_ready_o,
    output logic              fifo_full_o,
    output logic              fe_o,
    output logic              pe_o,
    output logic              brk_o,
    output logic              overrun_o,
    output logic              irq_o,
    output logic              rts_n_o
);

    rxq_err_t push_err, head_err, report;

    assign push_err = '{brk: push_brk_i, pe: push_pe_i, fe: push_fe_i};

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .push_err_i  (push_err),
        .pop_i       (pop_i),
        .rst_err_i   (rst_err_i),
        .head_data_o (rd_data_o),
        .head_err_o  (head_err),
        .not_empty_o (rx_ready_o),
        .full_o      (fifo_full_o),
        .overrun_o   (overrun_o)
    );

    rxq_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_err_i   (head_err),
        .head_valid_i (rx_ready_o),
        .blk_mode_i   (blk_mode_i),
        .rst_err_i    (rst_err_i),
        .report_o     (report)
    );

    rxq_flow u_flow (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_en_i   (rts_auto_en_i),
        .start_bit_i (start_bit_i),
        .full_i      (fifo_full_o),
        .sw_req_i    (rts_sw_i),
        .rts_n_o     (rts_n_o)
    );

    assign fe_o  = report.fe;
    assign pe_o  = report.pe;
    assign brk_o = report.brk;
    assign irq_o = irq_full_sel_i ? fifo_full_o : rx_ready_o;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic clk,
    input logic rst_n,
    input logic push_i,
    input logic pop_i,
    input logic start_bit_i,
    input logic rst_err_i,
    input logic blk_mode_i,
    input logic rts_auto_en_i,
    input logic rts_sw_i,
    input logic rx_ready_o,
    input logic fifo_full_o,
    input logic fe_o,
    input logic pe_o,
    input logic brk_o,
    input logic overrun_o,
    input logic rts_n_o
);

    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_o |-> rx_ready_o); // R1

    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready_o && pop_i && !push_i) |=> !rx_ready_o); // R2

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && fifo_full_o && !rst_err_i) |=> overrun_o); // R3

    AST_EMPTY_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_mode_i && !rx_ready_o) |-> !(fe_o || pe_o || brk_o)); // R5

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_err_i |=> !overrun_o); // R7

    AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en_i && start_bit_i && fifo_full_o) |=> rts_n_o); // R9

    AST_RTS_SW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_sw_i |-> rts_n_o); // R10

endmodule

bind rxq_top rxq_checker u_rxq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_i        (push_i),
    .pop_i         (pop_i),
    .start_bit_i   (start_bit_i),
    .rst_err_i     (rst_err_i),
    .blk_mode_i    (blk_mode_i),
    .rts_auto_en_i (rts_auto_en_i),
    .rts_sw_i      (rts_sw_i),
    .rx_ready_o    (rx_ready_o),
    .fifo_full_o   (fifo_full_o),
    .fe_o          (fe_o),
    .pe_o          (pe_o),
    .brk_o         (brk_o),
    .overrun_o     (overrun_o),
    .rts_n_o       (rts_n_o)
);

// File: tb/rxq_top_test.sv
module rxq_top_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       push_fe_i = 1'b0, push_pe_i = 1'b0, push_brk_i = 1'b0;
    logic       start_bit_i = 1'b0, pop_i = 1'b0, rst_err_i = 1'b0;
    logic       blk_mode_i = 1'b0, irq_full_sel_i = 1'b0;
    logic       rts_auto_en_i = 1'b0, rts_sw_i = 1'b1;
    logic [7:0] rd_data_o;
    logic       rx_ready_o, fifo_full_o, fe_o, pe_o, brk_o, overrun_o, irq_o, rts_n_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    rxq_top uut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .push_fe_i(push_fe_i), .push_pe_i(push_pe_i), .push_brk_i(push_brk_i),
        .start_bit_i(start_bit_i), .pop_i(pop_i), .rst_err_i(rst_err_i),
        .blk_mode_i(blk_mode_i), .irq_full_sel_i(irq_full_sel_i),
        .rts_auto_en_i(rts_auto_en_i), .rts_sw_i(rts_sw_i),
        .rd_data_o(rd_data_o), .rx_ready_o(rx_ready_o), .fifo_full_o(fifo_full_o),
        .fe_o(fe_o), .pe_o(pe_o), .brk_o(brk_o), .overrun_o(overrun_o),
        .irq_o(irq_o), .rts_n_o(rts_n_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock cycle with the given strobes; returns at the following falling edge.
    task automatic step(input logic psh, input logic [7:0] d, input logic [2:0] bpf,
                        input logic pp, input logic sb, input logic re);
        @(negedge clk);
        push_i = psh; push_data_i = d;
        push_brk_i = bpf[2]; push_pe_i = bpf[1]; push_fe_i = bpf[0];
        pop_i = pp; start_bit_i = sb; rst_err_i = re;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; start_bit_i = 1'b0; rst_err_i = 1'b0;
        push_brk_i = 1'b0; push_pe_i = 1'b0; push_fe_i = 1'b0;
        #1;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] bpf);
        step(1'b1, d, bpf, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pop();
        step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        blk_mode_i = 1'b0; irq_full_sel_i = 1'b0; rts_auto_en_i = 1'b0; rts_sw_i = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R11 ready", rx_ready_o, 0);
        check("R11 full", fifo_full_o, 0);
        check("R11 overrun", overrun_o, 0);
        check("R11 status", {brk_o, pe_o, fe_o}, 0);
        check("R11 rts_n", rts_n_o, 0);
    endtask

    task automatic t_order();
        do_reset();
        push(8'hA1, 3'b000);
        push(8'hA2, 3'b000);
        check("R1 ready", rx_ready_o, 1);
        check("R1 head first", rd_data_o, 8'hA1);
        pop();
        check("R1 head second", rd_data_o, 8'hA2);
        pop();
        check("R1 empty", rx_ready_o, 0);
    endtask

    task automatic t_pop_empty();
        do_reset();
        pop();
        check("R2 still empty", rx_ready_o, 0);
        push(8'h55, 3'b000);
        check("R2 head", rd_data_o, 8'h55);
        pop();
        check("R2 single char", rx_ready_o, 0);
    endtask

    task automatic t_overrun();
        do_reset();
        push(8'h11, 3'b000);
        push(8'h22, 3'b000);
        check("R3 not full at 2", fifo_full_o, 0);
        push(8'h33, 3'b000);
        check("R3 full", fifo_full_o, 1);
        check("R3 no overrun yet", overrun_o, 0);
        push(8'h99, 3'b000);
        check("R3 overrun", overrun_o, 1);
        // push plus pop on a full queue: push dropped
        step(1'b1, 8'h77, 3'b000, 1'b1, 1'b0, 1'b0);
        check("R3 full push+pop head", rd_data_o, 8'h22);
        check("R3 full push+pop not full", fifo_full_o, 0);
        pop();
        check("R3 third", rd_data_o, 8'h33);
        pop();
        check("R3 drained", rx_ready_o, 0);
    endtask

    task automatic t_balanced();
        do_reset();
        push(8'h01, 3'b000);
        push(8'h02, 3'b000);
        step(1'b1, 8'h03, 3'b000, 1'b1, 1'b0, 1'b0);
        check("R4 head", rd_data_o, 8'h02);
        check("R4 not full", fifo_full_o, 0);
        pop();
        check("R4 next", rd_data_o, 8'h03);
        pop();
        check("R4 empty", rx_ready_o, 0);
    endtask

    task automatic t_char_mode();
        do_reset();
        push(8'h10, 3'b001);
        push(8'h20, 3'b010);
        push(8'h30, 3'b100);
        check("R5 head fe", {brk_o, pe_o, fe_o}, 3'b001);
        pop();
        check("R5 head pe", {brk_o, pe_o, fe_o}, 3'b010);
        pop();
        check("R5 head brk", {brk_o, pe_o, fe_o}, 3'b100);
        pop();
        check("R5 empty clean", {brk_o, pe_o, fe_o}, 3'b000);
    endtask

    task automatic t_block_mode();
        do_reset();
        blk_mode_i = 1'b1;
        push(8'h10, 3'b001);
        push(8'h20, 3'b010);
        push(8'h30, 3'b000);
        check("R6 first head", {brk_o, pe_o, fe_o}, 3'b001);
        pop();
        check("R6 accum two", {brk_o, pe_o, fe_o}, 3'b011);
        pop();
        check("R6 clean head keeps", {brk_o, pe_o, fe_o}, 3'b011);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
        check("R7 block cleared", {brk_o, pe_o, fe_o}, 3'b000);
        push(8'h40, 3'b100);
        pop();
        check("R6 after pops", {brk_o, pe_o, fe_o}, 3'b100);
    endtask

    task automatic t_err_clear();
        do_reset();
        push(8'h01, 3'b000); push(8'h02, 3'b000); push(8'h03, 3'b000);
        push(8'h04, 3'b000);
        check("R7 overrun set", overrun_o, 1);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
        check("R7 overrun cleared", overrun_o, 0);
        step(1'b1, 8'h05, 3'b000, 1'b0, 1'b0, 1'b1);
        check("R7 clear wins", overrun_o, 0);
    endtask

    task automatic t_irq();
        do_reset();
        check("R8 idle", irq_o, 0);
        push(8'h01, 3'b000);
        check("R8 ready source", irq_o, 1);
        irq_full_sel_i = 1'b1; #1;
        check("R8 full source partial", irq_o, 0);
        push(8'h02, 3'b000); push(8'h03, 3'b000);
        check("R8 full source full", irq_o, 1);
    endtask

    task automatic t_rts();
        do_reset();
        push(8'h01, 3'b000); push(8'h02, 3'b000);
        rts_auto_en_i = 1'b1;
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        check("R9 not full no hold", rts_n_o, 0);
        push(8'h03, 3'b000);
        rts_auto_en_i = 1'b0;
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        check("R9 disabled no hold", rts_n_o, 0);
        rts_auto_en_i = 1'b1;
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        check("R9 hold", rts_n_o, 1);
        check("R10 sw unchanged", rts_sw_i, 1);
        pop();
        @(negedge clk); #1;
        check("R10 auto release", rts_n_o, 0);
        rts_sw_i = 1'b0; #1;
        check("R10 sw negate", rts_n_o, 1);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_pop_empty();
        t_overrun();
        t_balanced();
        t_char_mode();
        t_block_mode();
        t_err_clear();
        t_irq();
        t_rts();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule